// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This master-side block frees a two-wire bus whose data line is held low by a target stranded in the middle of a transfer, for example after a reset or a brown-out on the master side. When it gets a request, it releases the data line and toggles the clock line through open-drain pull-down enables. At the end of every clock-high phase it looks at the data line. The first time the data line is seen high, the block stops clocking. It then issues a START followed by a STOP, which leaves every target idle and the bus free.

The block never emits more than nine clock pulses. If the data line is still low after the ninth high phase, the block lets go of both lines and raises a failure flag next to its completion flag. Two inputs set the length of the high phase and of the low phase in system clocks. A value of zero selects a built-in default derived from the system clock frequency. The defaults give at least 0.6 µs high and 1.3 µs low.

Top module: `twi_recover`

## Requirements
- R1: After reset, and after any reset that arrives during a recovery, both line enables are deasserted and `done` and `fail` are low.
- R2: An accepted request starts with a low phase of `lo_len` system clocks (SCL pulled, SDA released), followed by a high phase of `hi_len` clocks (both released), and repeats this pair. A value of 0 selects ceil(1300 ns × CLK_MHZ / 1000) clocks for the low phase and ceil(600 ns × CLK_MHZ / 1000) clocks for the high phase. With the default CLK_MHZ = 50 these are 65 and 30.
- R3: `sda_in` is sampled in the last cycle of each high phase. If it reads 1, clocking ends. The number of pulses equals the index of the first high phase in which SDA reads high.
- R4: At most 9 pulses are issued. If SDA still reads low at the end of the ninth high phase, both lines are released and `done` and `fail` both go to 1.
- R5: After a successful sample, the block produces these steps in order: SDA is pulled while SCL stays released, for one high phase (START); then SCL and SDA are both pulled for one low phase; then SCL is released with SDA still pulled for one high phase; then SDA is released. Only at that point does `done` go to 1, with `fail` at 0.
- R6: `done` and `fail` hold their value until the next accepted request and read 0 from the cycle after that request.
- R7: A `go` pulse while a recovery is running has no effect: the running sequence continues unchanged and no second sequence follows.
- R8: The phase lengths are captured when the request is accepted. A change on `hi_len` or `lo_len` during a recovery does not alter that recovery's phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Recovery request, accepted when idle |
| hi_len | input | DIV_W | High-phase length in clocks, 0 selects the default |
| lo_len | input | DIV_W | Low-phase length in clocks, 0 selects the default |
| sda_in | input | 1 | Synchronised level of the data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| done | output | 1 | Recovery finished (held) |
| fail | output | 1 | Data line never released within nine pulses (held) |

## Verification
The success decision and the give-up decision are made in the same cycle: the last cycle of the ninth high phase, when the pulse limit has been reached and SDA is sampled in that same cycle. A modelled target releases SDA a programmable number of SCL falls after the request. A release count of nine must give a START with nine pulses and no failure. A release count of ten must give `fail` with exactly nine pulses and no START. A second collision, a new request arriving while a sequence is running, is provoked by pulsing `go` mid-run; the recorded line trace must be identical to an undisturbed run.

// File: rtl/twi_recover_pkg.sv
package twi_recover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CLK_LO  = 3'd1,
    ST_CLK_HI  = 3'd2,
    ST_START   = 3'd3,
    ST_STOP_LO = 3'd4,
    ST_STOP_HI = 3'd5
  } rec_state_e;

  // Smallest clock count that covers a span of ns at a clock of mhz.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/twi_phase_timer.sv
module twi_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));

endmodule

// File: rtl/twi_pulse_counter.sv
module twi_pulse_counter #(
  parameter int LIMIT = 9,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_limit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (inc)  count <= count + 1'b1;
  end

  assign at_limit = (count == CW'(LIMIT));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (count < CW'(LIMIT)));

endmodule

// File: rtl/twi_recover.sv
module twi_recover #(
  parameter int DIV_W      = 8,
  parameter int MAX_PULSES = 9,
  parameter int CLK_MHZ    = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] hi_len,
  input  logic [DIV_W-1:0] lo_len,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             done,
  output logic             fail
);
  import twi_recover_pkg::*;

  localparam int CW       = $clog2(MAX_PULSES + 1);
  localparam int DEF_HI_I = ns_to_cycles(600, CLK_MHZ);
  localparam int DEF_LO_I = ns_to_cycles(1300, CLK_MHZ);
  localparam logic [DIV_W-1:0] DEF_HI = DIV_W'((DEF_HI_I < 1) ? 1 : DEF_HI_I);
  localparam logic [DIV_W-1:0] DEF_LO = DIV_W'((DEF_LO_I < 1) ? 1 : DEF_LO_I);

  function automatic logic [DIV_W-1:0] pick_len(input logic [DIV_W-1:0] req,
                                                input logic [DIV_W-1:0] dflt);
    return (req == '0) ? dflt : req;
  endfunction

  rec_state_e       state, nxt;
  logic [DIV_W-1:0] hi_q, lo_q, t_len;
  logic             t_load, t_exp, p_inc, p_clr, at_limit;
  logic [CW-1:0]    pulse_cnt;

  // Named events for the checks below.
  logic accept_evt, start_evt, give_up_evt, stop_evt;
  assign accept_evt  = (state == ST_IDLE) && go;
  assign start_evt   = (state == ST_CLK_HI) && t_exp && sda_in;
  assign give_up_evt = (state == ST_CLK_HI) && t_exp && !sda_in && at_limit;
  assign stop_evt    = (state == ST_STOP_HI) && t_exp;

  twi_phase_timer #(.W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expired(t_exp)
  );

  twi_pulse_counter #(.LIMIT(MAX_PULSES), .CW(CW)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .inc(p_inc),
    .count(pulse_cnt), .at_limit(at_limit)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_len  = lo_q;
    p_inc  = 1'b0;
    p_clr  = 1'b0;
    unique case (state)
      ST_IDLE: if (go) begin
        nxt = ST_CLK_LO; t_load = 1'b1; t_len = pick_len(lo_len, DEF_LO); p_clr = 1'b1;
      end
      ST_CLK_LO: if (t_exp) begin
        nxt = ST_CLK_HI; t_load = 1'b1; t_len = hi_q; p_inc = 1'b1;
      end
      ST_CLK_HI: if (t_exp) begin
        if (sda_in) begin
          nxt = ST_START; t_load = 1'b1; t_len = hi_q;
        end else if (at_limit) begin
          nxt = ST_IDLE;
        end else begin
          nxt = ST_CLK_LO; t_load = 1'b1; t_len = lo_q;
        end
      end
      ST_START: if (t_exp) begin
        nxt = ST_STOP_LO; t_load = 1'b1; t_len = lo_q;
      end
      ST_STOP_LO: if (t_exp) begin
        nxt = ST_STOP_HI; t_load = 1'b1; t_len = hi_q;
      end
      ST_STOP_HI: if (t_exp) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hi_q  <= DEF_HI;
      lo_q  <= DEF_LO;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= nxt;
      if (accept_evt) begin
        hi_q <= pick_len(hi_len, DEF_HI);
        lo_q <= pick_len(lo_len, DEF_LO);
        done <= 1'b0;
        fail <= 1'b0;
      end
      if (give_up_evt) begin
        done <= 1'b1;
        fail <= 1'b1;
      end
      if (stop_evt) done <= 1'b1;
    end
  end

  assign scl_drive_low = (state == ST_CLK_LO) || (state == ST_STOP_LO);
  assign sda_drive_low = (state == ST_START) || (state == ST_STOP_LO) ||
                         (state == ST_STOP_HI);

  // R5
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> (!scl_drive_low && $past(start_evt)));

  // R5
  stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> (!scl_drive_low && $past(stop_evt) && done && !fail));

  // R4
  give_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (done && ($past(pulse_cnt) == CW'(MAX_PULSES)) && !$past(sda_in)));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !go && done) |=> (done && $stable(fail)));

endmodule

// File: tb/test_twi_recover.sv
module test_twi_recover;
  localparam int CLK_NS  = 10;
  localparam int DIV_W   = 8;
  localparam int CLK_MHZ = 50;
  localparam int LIMIT   = 9;
  localparam int DEF_HI  = (600 * CLK_MHZ + 999) / 1000;
  localparam int DEF_LO  = (1300 * CLK_MHZ + 999) / 1000;
  localparam int NV      = 7;
  // hi_len, lo_len, target release after this many SCL falls
  localparam int VEC [0:NV-1][0:2] = '{
    '{2, 3, 0}, '{1, 1, 1}, '{3, 2, 4}, '{2, 2, 9},
    '{2, 1, 10}, '{0, 0, 2}, '{4, 1, 12}
  };

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [DIV_W-1:0] hi_len = '0, lo_len = '0;
  logic tgt_hold = 1'b0;
  logic sda_in, scl_drive_low, sda_drive_low, done, fail;

  assign sda_in = !sda_drive_low && !tgt_hold;

  twi_recover #(.DIV_W(DIV_W), .MAX_PULSES(LIMIT), .CLK_MHZ(CLK_MHZ)) i_twi_recover (
    .clk(clk), .rst_n(rst_n), .go(go), .hi_len(hi_len), .lo_len(lo_len),
    .sda_in(sda_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .done(done), .fail(fail)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0, fails = 0;
  int seg_code [0:63];
  int seg_len  [0:63];
  int nseg;
  bit timed_out;
  int done_after_go;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one request and records the line trace as {scl,sda} segments.
  task automatic run(input int h, input int l, input int k,
                     input int h2, input int l2, input bit go_again);
    int prev, runlen, cur, falls, cyc;
    bit started, prev_scl;
    hi_len = DIV_W'(h); lo_len = DIV_W'(l);
    falls = 0; tgt_hold = (k > 0);
    nseg = 0; timed_out = 0;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0; hi_len = DIV_W'(h2); lo_len = DIV_W'(l2);
    done_after_go = int'(done);
    prev = 0; runlen = 0; started = 0; prev_scl = 1'b0; cyc = 0;
    forever begin
      cur = {30'd0, scl_drive_low, sda_drive_low};
      if (scl_drive_low && !prev_scl) falls++;
      prev_scl = scl_drive_low;
      tgt_hold = (falls < k);
      if (cur != prev) begin
        if (started && nseg < 64) begin
          seg_code[nseg] = prev; seg_len[nseg] = runlen; nseg++;
        end
        started = 1; runlen = 1; prev = cur;
      end else runlen++;
      if (done) break;
      go = (go_again && cyc == 5);
      cyc++;
      if (cyc > 5000) begin timed_out = 1; break; end
      @(negedge clk);
    end
    go = 1'b0;
  endtask

  task automatic judge(input int h, input int l, input int k);
    int eh, el, p, ef, n10, phase_ok, tail_ok;
    eh = (h == 0) ? DEF_HI : h;
    el = (l == 0) ? DEF_LO : l;
    p  = (k < 1) ? 1 : ((k > LIMIT) ? LIMIT : k);
    ef = (k > LIMIT) ? 1 : 0;
    chk("R5 run completes", int'(timed_out), 0);
    chk("R6 flags cleared after request", done_after_go, 0);
    chk("R4 fail flag", int'(fail), ef);
    n10 = 0; phase_ok = 1;
    for (int i = 0; i < nseg; i++) if (seg_code[i] == 2) n10++;
    chk("R3 pulse count", n10, p);
    chk("R2 first low phase", seg_len[0], el);
    chk("R2 first high phase", seg_len[1], eh);
    for (int i = 0; i < 2 * p - 1; i++)
      if (seg_code[i] != ((i % 2 == 0) ? 2 : 0) ||
          seg_len[i] != ((i % 2 == 0) ? el : eh)) phase_ok = 0;
    chk("R2 all clock phases", phase_ok, 1);
    if (ef == 0) begin
      chk("R5 segment count", nseg, 2 * p + 3);
      tail_ok = (seg_code[2*p-1] == 0 && seg_len[2*p-1] == eh &&
                 seg_code[2*p]   == 1 && seg_len[2*p]   == eh &&
                 seg_code[2*p+1] == 3 && seg_len[2*p+1] == el &&
                 seg_code[2*p+2] == 1 && seg_len[2*p+2] == eh) ? 1 : 0;
      chk("R5 start then stop order", tail_ok, 1);
    end else begin
      chk("R4 segment count at give-up", nseg, 2 * p - 1);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", int'({scl_drive_low, sda_drive_low, done, fail}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({scl_drive_low, sda_drive_low, done, fail}), 0);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][0], VEC[v][1], 1'b0);
      judge(VEC[v][0], VEC[v][1], VEC[v][2]);
    end

    // R6 flags held while idle (last vector failed)
    repeat (20) @(negedge clk);
    chk("R6 done held", int'(done), 1);
    chk("R6 fail held", int'(fail), 1);

    // R8 phase lengths captured at acceptance
    run(3, 4, 2, 7, 7, 1'b0);
    judge(3, 4, 2);

    // R7 request during a running recovery
    run(2, 2, 3, 2, 2, 1'b1);
    judge(2, 2, 3);
    repeat (10) @(negedge clk);
    chk("R7 no second sequence", int'(scl_drive_low | sda_drive_low), 0);
    chk("R7 done still held", int'(done), 1);

    // R1 reset in the middle of a recovery
    hi_len = 8'd5; lo_len = 8'd5; tgt_hold = 1'b1;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 clocking before reset", int'(scl_drive_low), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 lines released by reset", int'({scl_drive_low, sda_drive_low, done, fail}), 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R1 stays idle after reset", int'({scl_drive_low, sda_drive_low, done, fail}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule